// File: doc/BRIEF.md
# Accumulated-Position Display Timing Generator

This block drives the raster timing of a parallel RGB panel from the pixel clock. A horizontal counter steps once per clock. A vertical counter steps once each time the horizontal counter wraps. Each counter is compared against four cumulative end positions: the last count of the sync pulse, the last count of the back porch, the last count of active video, and the last count of the whole line or frame. These comparisons give the horizontal sync, vertical sync and data-enable pins, plus the current pixel position.

Each end position arrives as a packed 32-bit word. The horizontal value sits in bits 27:16 and the vertical value sits in bits 10:0. Each of the three pins rests active-low unless its own control bit makes it active-high. A pixel-clock inversion choice is captured while the block is idle and passed on to the clocking logic outside the block. A one-cycle line pulse fires at the start of a programmed line. Placing that line one past the last active line marks the entry into vertical blanking.

Top module: `disp_timing_gen`

## Requirements
- R1: While `enable` is low, or in the cycle after reset, `pos_x` and `pos_y` read 0, `line_irq` is 0, and every sync/DE pin sits at its inactive level.
- R2: While enabled, `pos_x` counts up by one each clock and returns to 0 on the clock after it equals the horizontal total.
- R3: `pos_y` changes only on the clock where `pos_x` wraps. At that clock it advances by one, or returns to 0 when it already equals the vertical total.
- R4: Horizontal sync is active for `pos_x` from 0 up to and including the horizontal sync field value.
- R5: Vertical sync is active for `pos_y` from 0 up to and including the vertical sync field value.
- R6: DE is active only when `pos_x` is greater than the horizontal back-porch field and no greater than the horizontal active field, and `pos_y` meets the same conditions with the vertical fields.
- R7: Each pin follows its own polarity bit. When the bit is 1, the pin is high while its signal is active. When the bit is 0, the pin is low while its signal is active.
- R8: `line_irq` is high for exactly the cycle in which `pos_x` is 0 and `pos_y` equals `line_irq_pos`. It never fires if that line lies beyond the vertical total.
- R9: In each timing word, only bits 27:16 (horizontal) and bits 10:0 (vertical) have any effect. All other bits are ignored.
- R10: `pclk_invert_o` takes the value of `pclk_invert` on each clock while disabled. While enabled it holds its value.
- R11: If a total is lowered below the present count, the counter returns to 0 at its next step instead of running on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Global run control |
| sync_word | input | 32 | Sync end positions (H in 27:16, V in 10:0) |
| bporch_word | input | 32 | Back-porch end positions |
| active_word | input | 32 | Active-video end positions |
| total_word | input | 32 | Line/frame last-count positions |
| hs_active_high | input | 1 | Horizontal sync pin active-high when 1 |
| vs_active_high | input | 1 | Vertical sync pin active-high when 1 |
| de_active_high | input | 1 | DE pin active-high when 1 |
| pclk_invert | input | 1 | Requested pixel-clock inversion |
| line_irq_pos | input | 11 | Line on which the line pulse fires |
| hsync | output | 1 | Horizontal sync pin |
| vsync | output | 1 | Vertical sync pin |
| de | output | 1 | Data-enable pin |
| pclk_invert_o | output | 1 | Captured pixel-clock inversion choice |
| pos_x | output | 12 | Current horizontal count |
| pos_y | output | 11 | Current vertical count |
| line_irq | output | 1 | One-cycle line-position pulse |

## Verification
The bench targets the window edges: the last count of sync, the first count after back porch, the last active count and the wrap count. An off-by-one comparison shows up there as a pin that is one pixel early or late. All eight polarity combinations are swept, and junk is placed in the unused word bits, so an inverted pin or a shifted field extraction produces mismatches on every line. The bench also lowers the total mid-line to catch a counter that runs past the new limit. It holds a clock-inversion change across an enabled interval to catch a capture that is not gated on idle. Finally, it places the line pulse both on the first line and past the frame end, to catch a pulse that repeats within a line or fires on a line that does not exist.

// File: rtl/disp_timing_pkg.sv
package disp_timing_pkg;

    localparam int WORD_W = 32;
    localparam int H_W    = 12;
    localparam int V_W    = 11;
    localparam int H_LSB  = 16;
    localparam int H_MSB  = H_LSB + H_W - 1;
    localparam int V_LSB  = 0;
    localparam int V_MSB  = V_LSB + V_W - 1;
    localparam int N_PINS = 3;

    localparam int PIN_HS = 0;
    localparam int PIN_VS = 1;
    localparam int PIN_DE = 2;

    typedef struct packed {
        logic [H_W-1:0] sync_end;
        logic [H_W-1:0] bp_end;
        logic [H_W-1:0] act_end;
        logic [H_W-1:0] total;
    } h_cfg_t;

    typedef struct packed {
        logic [V_W-1:0] sync_end;
        logic [V_W-1:0] bp_end;
        logic [V_W-1:0] act_end;
        logic [V_W-1:0] total;
    } v_cfg_t;

endpackage

// File: rtl/dt_axis_counter.sv
module dt_axis_counter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         adv,
    input  logic [W-1:0] tot,
    output logic [W-1:0] cnt,
    output logic         wrap
);

    assign wrap = adv && (cnt >= tot);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= wrap ? '0 : cnt + W'(1);
        end
    end

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (run && adv && cnt >= tot) |=> (cnt == '0)); // R11
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (run && adv && cnt < tot) |=> (!run || cnt == $past(cnt) + W'(1))); // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run && !adv) |=> (!run || $stable(cnt))); // R3

endmodule

// File: rtl/dt_axis_decode.sv
module dt_axis_decode #(
    parameter int W = 12
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] sync_end,
    input  logic [W-1:0] bp_end,
    input  logic [W-1:0] act_end,
    output logic         sync_act,
    output logic         in_window
);

    assign sync_act  = (cnt <= sync_end);
    assign in_window = (cnt > bp_end) && (cnt <= act_end);

endmodule

// File: rtl/dt_pin_polarity.sv
module dt_pin_polarity #(
    parameter int N = 3
) (
    input  logic         run,
    input  logic [N-1:0] act,
    input  logic [N-1:0] hi,
    output logic [N-1:0] pin
);

    for (genvar g = 0; g < N; g++) begin : g_pin
        assign pin[g] = (run && act[g]) ? hi[g] : ~hi[g];
    end

endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
    import disp_timing_pkg::*;
#(
    parameter int HW = H_W,
    parameter int VW = V_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [WORD_W-1:0] sync_word,
    input  logic [WORD_W-1:0] bporch_word,
    input  logic [WORD_W-1:0] active_word,
    input  logic [WORD_W-1:0] total_word,
    input  logic              hs_active_high,
    input  logic              vs_active_high,
    input  logic              de_active_high,
    input  logic              pclk_invert,
    input  logic [VW-1:0]     line_irq_pos,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic              pclk_invert_o,
    output logic [HW-1:0]     pos_x,
    output logic [VW-1:0]     pos_y,
    output logic              line_irq
);

    h_cfg_t hc;
    v_cfg_t vc;

    assign hc.sync_end = sync_word  [H_MSB:H_LSB];
    assign hc.bp_end   = bporch_word[H_MSB:H_LSB];
    assign hc.act_end  = active_word[H_MSB:H_LSB];
    assign hc.total    = total_word [H_MSB:H_LSB];
    assign vc.sync_end = sync_word  [V_MSB:V_LSB];
    assign vc.bp_end   = bporch_word[V_MSB:V_LSB];
    assign vc.act_end  = active_word[V_MSB:V_LSB];
    assign vc.total    = total_word [V_MSB:V_LSB];

    logic unused_word_bits;
    assign unused_word_bits = ^{sync_word[WORD_W-1:H_MSB+1],   sync_word[H_LSB-1:V_MSB+1],
                                bporch_word[WORD_W-1:H_MSB+1], bporch_word[H_LSB-1:V_MSB+1],
                                active_word[WORD_W-1:H_MSB+1], active_word[H_LSB-1:V_MSB+1],
                                total_word[WORD_W-1:H_MSB+1],  total_word[H_LSB-1:V_MSB+1]};

    logic [HW-1:0] h_cnt;
    logic [VW-1:0] v_cnt;
    logic          h_wrap, v_wrap_unused;

    dt_axis_counter #(.W(HW)) u_hcnt (
        .clk(clk), .rst(rst), .run(enable), .adv(1'b1),
        .tot(hc.total), .cnt(h_cnt), .wrap(h_wrap)
    );

    dt_axis_counter #(.W(VW)) u_vcnt (
        .clk(clk), .rst(rst), .run(enable), .adv(h_wrap),
        .tot(vc.total), .cnt(v_cnt), .wrap(v_wrap_unused)
    );

    logic hs_act, vs_act, h_win, v_win;

    dt_axis_decode #(.W(HW)) u_hdec (
        .cnt(h_cnt), .sync_end(hc.sync_end), .bp_end(hc.bp_end),
        .act_end(hc.act_end), .sync_act(hs_act), .in_window(h_win)
    );

    dt_axis_decode #(.W(VW)) u_vdec (
        .cnt(v_cnt), .sync_end(vc.sync_end), .bp_end(vc.bp_end),
        .act_end(vc.act_end), .sync_act(vs_act), .in_window(v_win)
    );

    logic [N_PINS-1:0] pin_act, pin_hi, pin_lvl;

    always_comb begin
        pin_act         = '0;
        pin_hi          = '0;
        pin_act[PIN_HS] = hs_act;
        pin_act[PIN_VS] = vs_act;
        pin_act[PIN_DE] = h_win && v_win;
        pin_hi[PIN_HS]  = hs_active_high;
        pin_hi[PIN_VS]  = vs_active_high;
        pin_hi[PIN_DE]  = de_active_high;
    end

    dt_pin_polarity #(.N(N_PINS)) u_pins (
        .run(enable), .act(pin_act), .hi(pin_hi), .pin(pin_lvl)
    );

    assign hsync = pin_lvl[PIN_HS];
    assign vsync = pin_lvl[PIN_VS];
    assign de    = pin_lvl[PIN_DE];

    always_ff @(posedge clk) begin
        if (rst) begin
            pclk_invert_o <= 1'b0;
        end else if (!enable) begin
            pclk_invert_o <= pclk_invert;
        end
    end

    assign pos_x    = h_cnt;
    assign pos_y    = v_cnt;
    assign line_irq = enable && (h_cnt == '0) && (v_cnt == line_irq_pos);

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (pos_x == '0 && pos_y == '0)); // R1
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (line_irq && hc.total != '0) |=> !line_irq); // R8
    AST_DE_NO_HS: assert property (@(posedge clk) disable iff (rst)
        (h_win && hc.bp_end >= hc.sync_end) |-> !hs_act); // R6
    AST_CLKINV_HOLD: assert property (@(posedge clk) disable iff (rst)
        enable |=> $stable(pclk_invert_o)); // R10

endmodule

// File: tb/disp_timing_gen_bench.sv
`timescale 1ns/1ps
module disp_timing_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [31:0] sync_word = '0, bporch_word = '0, active_word = '0, total_word = '0;
    logic        hs_hi = 1'b0, vs_hi = 1'b0, de_hi = 1'b0, pinv = 1'b0;
    logic [10:0] lpos = '0;
    logic        hsync, vsync, de, pinv_o, line_irq;
    logic [11:0] pos_x;
    logic [10:0] pos_y;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    disp_timing_gen u_disp_timing_gen (
        .clk(clk), .rst(rst), .enable(enable),
        .sync_word(sync_word), .bporch_word(bporch_word),
        .active_word(active_word), .total_word(total_word),
        .hs_active_high(hs_hi), .vs_active_high(vs_hi), .de_active_high(de_hi),
        .pclk_invert(pinv), .line_irq_pos(lpos),
        .hsync(hsync), .vsync(vsync), .de(de), .pclk_invert_o(pinv_o),
        .pos_x(pos_x), .pos_y(pos_y), .line_irq(line_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int lvl(input bit a, input bit hi);
        return hi ? int'(a) : int'(!a);
    endfunction

    // R9: junk in bits 31:28 and 15:11 must be ignored
    function automatic logic [31:0] pack(input int h, input int v);
        return {4'hA, h[11:0], 5'b10101, v[10:0]};
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic sweep(input int hs, input int hb, input int ha, input int ht,
                         input int vs, input int vb, input int va, input int vt,
                         input int lp, input int frames, input bit [2:0] pol);
        sync_word   = pack(hs, vs);
        bporch_word = pack(hb, vb);
        active_word = pack(ha, va);
        total_word  = pack(ht, vt);
        hs_hi = pol[0]; vs_hi = pol[1]; de_hi = pol[2];
        lpos = 11'(lp);
        enable = 1'b1;
        #1;
        for (int n = 0; n < frames * (ht + 1) * (vt + 1); n++) begin
            int hh = n % (ht + 1);
            int vv = (n / (ht + 1)) % (vt + 1);
            bit hsa = (hh <= hs);
            bit vsa = (vv <= vs);
            bit dea = (hh > hb) && (hh <= ha) && (vv > vb) && (vv <= va);
            chk("R2 pos_x", int'(pos_x), hh);
            chk("R3 pos_y", int'(pos_y), vv);
            chk("R4/R7/R9 hsync", int'(hsync), lvl(hsa, pol[0]));
            chk("R5/R7/R9 vsync", int'(vsync), lvl(vsa, pol[1]));
            chk("R6/R7 de", int'(de), lvl(dea, pol[2]));
            chk("R8 line_irq", int'(line_irq), int'(hh == 0 && vv == lp));
            step();
        end
        @(negedge clk);
        enable = 1'b0;
        step();
        chk("R1 idle pos_x", int'(pos_x), 0);
        chk("R1 idle pos_y", int'(pos_y), 0);
        chk("R1 idle hsync", int'(hsync), lvl(1'b0, pol[0]));
        chk("R1 idle vsync", int'(vsync), lvl(1'b0, pol[1]));
        chk("R1 idle de", int'(de), lvl(1'b0, pol[2]));
        chk("R1 idle irq", int'(line_irq), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R1 reset pos_x", int'(pos_x), 0);
        chk("R1 reset pos_y", int'(pos_y), 0);
        chk("R1 reset hsync", int'(hsync), 1);
        chk("R1 reset vsync", int'(vsync), 1);
        chk("R1 reset de", int'(de), 1);
        chk("R1 reset irq", int'(line_irq), 0);
        rst = 1'b0;
        step();

        for (int p = 0; p < 8; p++) begin
            sweep(1, 3, 7, 9, 0, 2, 5, 6, 6, 2, 3'(p));
        end
        sweep(0, 1, 4, 5, 1, 2, 3, 4, 0, 2, 3'b101);
        sweep(2, 4, 8, 11, 1, 3, 6, 8, 20, 1, 3'b010);  // R8 line beyond total

        // R11: lower the horizontal total below the current count
        sync_word = pack(1, 0); bporch_word = pack(3, 2);
        active_word = pack(7, 5); total_word = pack(9, 6);
        enable = 1'b1;
        repeat (7) step();
        total_word = pack(3, 6);
        #1;
        chk("R11 before cut", int'(pos_x), 7);
        step();
        chk("R11 wrapped x", int'(pos_x), 0);
        chk("R11 wrapped y", int'(pos_y), 1);
        step();
        chk("R11 next x", int'(pos_x), 1);
        @(negedge clk);
        enable = 1'b0;
        step();

        // R10: inversion captured only while idle
        pinv = 1'b1;
        step();
        chk("R10 capture idle", int'(pinv_o), 1);
        enable = 1'b1;
        pinv = 1'b0;
        step();
        step();
        chk("R10 hold enabled", int'(pinv_o), 1);
        enable = 1'b0;
        step();
        chk("R10 capture after disable", int'(pinv_o), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule